// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Bus Interface

This block is the digital half of an 8-bit successive-approximation converter. A host controls it with three active-low lines: a select, an enable and a direction line. When all three are held low together for long enough, a conversion is qualified. The block then presents a trial code to an external DAC, reads back a one-bit comparator decision for each bit from the most significant down, and latches the final code. A busy flag stays high for the whole bit search.

When the direction line is high with select and enable low, and no conversion is running, the block drives the latched code onto a tri-state data bus after a fixed access delay. Raising select or enable, or lowering the direction line, ends the read. The bus keeps driving for a short hold interval and then floats. If the direction line stays low through the end of a conversion, the block restarts after a short reset interval and keeps converting. After the direction line rises, the conversion in progress is the last one, and its code is the one kept.

All delays are counted in clock cycles and set by parameters. The comparator is a plain digital input. The code is offset binary, so the code follows the analog input linearly from 0x00 to 0xFF.

Top module: `sarBusCtrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `status` is low and `dataOe` is low.
- R2: A conversion starts only after `csN`, `ceN` and `rwN` have all been sampled low on START_MIN consecutive clock edges, in whatever order they fell. `status` is high right after the START_MIN-th such edge. A shorter overlap never raises `status`.
- R3: `status` stays high for exactly DATA_W cycles. In each of these cycles `trialCode` is tested from the MSB down: a bit is kept when `cmpIn` is 1 and cleared when it is 0. With an ideal comparator (`cmpIn` = input code >= `trialCode`), the latched code equals the input code, with 0x00 as the lowest input and 0xFF as the highest.
- R4: A full start request that is made and removed while `status` is high has no effect. The running conversion keeps its length and its result, and no second conversion follows.
- R5: `dataOe` is never high while a conversion or its reset interval is in progress. A read request made during a conversion drives the bus ACCESS_CYC cycles after `status` falls.
- R6: From idle, with `rwN` high and `csN`, `ceN` low, `dataOe` rises after ACCESS_CYC sampled edges and `busData` carries the latched code while it is high.
- R7: When `csN` or `ceN` rises, or `rwN` falls, during a driven read, `dataOe` stays high for HOLD_CYC more cycles and then falls.
- R8: While `csN`, `ceN` and `rwN` stay low at the end of a conversion, `status` is low for exactly RESET_GAP cycles and then a new conversion starts without fresh qualification.
- R9: After `rwN` rises during a repeating conversion, that conversion completes, no further conversion starts, and a later read returns its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Select, active low |
| ceN | input | 1 | Enable, active low |
| rwN | input | 1 | Direction: low requests a conversion, high requests a read |
| cmpIn | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| trialCode | output | DATA_W | Trial code for the external DAC |
| status | output | 1 | High while the bit search runs |
| dataOe | output | 1 | High while the data bus is driven |
| busData | output | DATA_W | Tri-state result bus, floating when `dataOe` is low |

## Verification
The bench cuts control overlaps one cycle short of the qualifying width. A design that counted non-consecutive low cycles, or qualified one edge early, would raise `status`. It issues a complete start request in the middle of a bit search. A design that did not ignore it would stretch or restart the search and lose the result. It raises a read during a conversion, which a design that let the buffer turn on early would drive. In continuous mode it measures the low interval between searches and checks that the last search before the direction line rose is the one kept. An off-by-one in the gap counter, or a stray extra conversion, shows up there.

// File: rtl/sarPkg.sv
package sarPkg;

  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } sarStrobe_t;

  typedef enum logic [1:0] {
    CV_IDLE = 2'd0,
    CV_BUSY = 2'd1,
    CV_GAP  = 2'd2
  } convState_t;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_DRIVE = 2'd1,
    RD_HOLD  = 2'd2
  } rdState_t;

endpackage

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strobe,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultQ
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sarReg;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] keptCode;

  // Decision for the bit under test: keep it when the comparator says high.
  assign keptCode  = cmpIn ? sarReg : (sarReg & ~bitMask);
  assign trialCode = sarReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg  <= '0;
      bitMask <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.load) begin
        sarReg  <= TOP_BIT;
        bitMask <= TOP_BIT;
      end else if (strobe.step) begin
        sarReg  <= keptCode | (bitMask >> 1);
        bitMask <= bitMask >> 1;
      end
      if (strobe.last) resultQ <= keptCode;
    end
  end

endmodule

// File: rtl/sarControl.sv
module sarControl
  import sarPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int START_MIN  = 4,
  parameter int ACCESS_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int RESET_GAP  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       ceN,
  input  logic       rwN,
  output sarStrobe_t strobe,
  output logic       status,
  output logic       dataOe
);
  localparam int QW = $clog2(START_MIN + 1);
  localparam int SW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int GW = $clog2(RESET_GAP + 1);
  localparam int AW = $clog2(ACCESS_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(START_MIN - 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(DATA_W - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(RESET_GAP - 1);
  localparam logic [AW-1:0] ACC_LAST  = AW'(ACCESS_CYC - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  convState_t cv;
  rdState_t   rd;
  logic [QW-1:0] lowCnt;
  logic [SW-1:0] stepCnt;
  logic [GW-1:0] gapCnt;
  logic [AW-1:0] accCnt;
  logic [HW-1:0] holdCnt;

  logic startReq, selReq, readReq, qualify, gapDone;

  assign startReq = !csN && !ceN && !rwN;
  assign selReq   = !csN && !ceN && rwN;
  assign readReq  = selReq && (cv == CV_IDLE);
  assign qualify  = (cv == CV_IDLE) && startReq && (lowCnt == QUAL_LAST);
  assign gapDone  = (cv == CV_GAP) && (gapCnt == GAP_LAST);

  assign strobe.load = qualify || (gapDone && startReq);
  assign strobe.step = (cv == CV_BUSY);
  assign strobe.last = (cv == CV_BUSY) && (stepCnt == STEP_LAST);

  assign status = (cv == CV_BUSY);
  assign dataOe = (rd != RD_IDLE) && (cv == CV_IDLE);

  // Conversion sequencer: qualify, bit search, inter-conversion gap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cv      <= CV_IDLE;
      lowCnt  <= '0;
      stepCnt <= '0;
      gapCnt  <= '0;
    end else begin
      unique case (cv)
        CV_IDLE: begin
          if (!startReq)               lowCnt <= '0;
          else if (lowCnt != QUAL_LAST) lowCnt <= lowCnt + 1'b1;
          if (qualify) begin
            cv      <= CV_BUSY;
            stepCnt <= '0;
            lowCnt  <= '0;
          end
        end
        CV_BUSY: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == STEP_LAST) begin
            cv     <= startReq ? CV_GAP : CV_IDLE;
            gapCnt <= '0;
          end
        end
        CV_GAP: begin
          if (gapDone) begin
            cv      <= startReq ? CV_BUSY : CV_IDLE;
            stepCnt <= '0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: cv <= CV_IDLE;
      endcase
    end
  end

  // Read sequencer: access delay, drive, hold before floating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rd      <= RD_IDLE;
      accCnt  <= '0;
      holdCnt <= '0;
    end else begin
      unique case (rd)
        RD_IDLE: begin
          if (!readReq) accCnt <= '0;
          else if (accCnt == ACC_LAST) begin
            rd     <= RD_DRIVE;
            accCnt <= '0;
          end else accCnt <= accCnt + 1'b1;
        end
        RD_DRIVE: begin
          if (!selReq) begin
            rd      <= RD_HOLD;
            holdCnt <= '0;
          end
        end
        RD_HOLD: begin
          if (holdCnt == HOLD_LAST) rd <= RD_IDLE;
          else                      holdCnt <= holdCnt + 1'b1;
        end
        default: rd <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sarBusCtrl.sv
module sarBusCtrl
  import sarPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int START_MIN  = 4,
  parameter int ACCESS_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int RESET_GAP  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              ceN,
  input  logic              rwN,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] trialCode,
  output logic              status,
  output logic              dataOe,
  output wire  [DATA_W-1:0] busData
);
  sarStrobe_t        strobe;
  logic [DATA_W-1:0] resultQ;

  sarControl #(
    .DATA_W(DATA_W), .START_MIN(START_MIN), .ACCESS_CYC(ACCESS_CYC),
    .HOLD_CYC(HOLD_CYC), .RESET_GAP(RESET_GAP)
  ) ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .ceN(ceN), .rwN(rwN),
    .strobe(strobe), .status(status), .dataOe(dataOe)
  );

  sarDatapath #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .trialCode(trialCode), .resultQ(resultQ)
  );

  assign busData = dataOe ? resultQ : {DATA_W{1'bz}};

endmodule

// File: rtl/sarBusCtrlChk.sv
module sarBusCtrlChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              ceN,
  input logic              rwN,
  input logic              status,
  input logic              dataOe,
  input logic [DATA_W-1:0] resultQ
);
  localparam int BW = $clog2(DATA_W + 2);

  logic [BW-1:0] busyRun;
  logic          startSeen;

  assign startSeen = !csN && !ceN && !rwN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       busyRun <= '0;
    else if (status) busyRun <= busyRun + 1'b1;
    else             busyRun <= '0;
  end

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status) |-> $past(startSeen)); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status) |-> (busyRun == BW'(DATA_W))); // R3

  AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultQ) |-> $fell(status)); // R3

  AST_NO_DRIVE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    status |-> !dataOe); // R5

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(resultQ)); // R6

endmodule

bind sarBusCtrl sarBusCtrlChk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .csN(csN), .ceN(ceN), .rwN(rwN),
  .status(status), .dataOe(dataOe), .resultQ(resultQ)
);

// File: tb/sarBusCtrl_test.sv
`timescale 1ns/1ps
module sarBusCtrl_test;
  localparam int DATA_W     = 8;
  localparam int START_MIN  = 4;
  localparam int ACCESS_CYC = 3;
  localparam int HOLD_CYC   = 2;
  localparam int RESET_GAP  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, ceN = 1'b1, rwN = 1'b1;
  logic [DATA_W-1:0] vin = '0;
  logic [DATA_W-1:0] trialCode;
  logic cmpIn, status, dataOe;
  wire  [DATA_W-1:0] busData;
  int nChecks = 0, nErr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Ideal comparator model for the external analog side.
  assign cmpIn = (vin >= trialCode);

  sarBusCtrl #(.DATA_W(DATA_W), .START_MIN(START_MIN), .ACCESS_CYC(ACCESS_CYC),
               .HOLD_CYC(HOLD_CYC), .RESET_GAP(RESET_GAP)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .ceN(ceN), .rwN(rwN), .cmpIn(cmpIn),
    .trialCode(trialCode), .status(status), .dataOe(dataOe), .busData(busData));

  function automatic logic [DATA_W-1:0] sarModel(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] t = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      t[b] = 1'b1;
      if (t > v) t[b] = 1'b0;
    end
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  task automatic dropLine(input int idx);
    case (idx)
      0: csN = 1'b0;
      1: ceN = 1'b0;
      default: rwN = 1'b0;
    endcase
  endtask

  // One conversion plus a read. midReq: full start request inside the search (R4).
  // endMode: 0 raise csN, 1 raise ceN, 2 lower rwN to end the read (R7).
  task automatic convertAndRead(input logic [DATA_W-1:0] v, input bit midReq, input int endMode);
    int first, busyCnt, lowSeen;
    logic [DATA_W-1:0] exp;
    exp = sarModel(v);
    vin = v;
    first = int'($urandom % 3);
    for (int k = 0; k < 3; k++) begin
      dropLine((first + k) % 3);
      if (k < 2) repeat (int'($urandom % 3)) begin
        tick();
        chk(status == 1'b0, "R2 partial overlap", status, 0);
      end
    end
    for (int i = 1; i < START_MIN; i++) begin
      tick();
      chk(status == 1'b0, "R2 early start", status, 0);
    end
    tick();
    chk(status == 1'b1, "R2 start after overlap", status, 1);
    rwN = 1'b1;
    busyCnt = 1;
    forever begin
      tick();
      if (!status) break;
      busyCnt++;
      chk(dataOe == 1'b0, "R5 bus during search", dataOe, 0);
      if (midReq && busyCnt == 3) rwN = 1'b0;
      if (midReq && busyCnt == 3 + START_MIN + 1) rwN = 1'b1;
      if (busyCnt > 40) break;
    end
    chk(busyCnt == DATA_W, "R3 search length", busyCnt, DATA_W);
    chk(dataOe == 1'b0, "R5 bus at search end", dataOe, 0);
    for (int i = 1; i < ACCESS_CYC; i++) begin
      tick();
      chk(dataOe == 1'b0, "R5 access delay", dataOe, 0);
    end
    tick();
    chk(dataOe == 1'b1, "R6 bus enabled", dataOe, 1);
    chk(busData == exp, "R3 result code", busData, exp);
    chk(status == 1'b0, "R4 no extra conversion", status, 0);
    case (endMode)
      0: csN = 1'b1;
      1: ceN = 1'b1;
      default: rwN = 1'b0;
    endcase
    for (int i = 0; i < HOLD_CYC; i++) begin
      tick();
      chk(dataOe == 1'b1 && busData == exp, "R7 hold", dataOe, 1);
    end
    tick();
    chk(dataOe == 1'b0, "R7 float", dataOe, 0);
    csN = 1'b1; ceN = 1'b1; rwN = 1'b1;
    lowSeen = 0;
    repeat (START_MIN + 2) begin
      tick();
      if (status) lowSeen++;
    end
    chk(lowSeen == 0, "R4 quiet after read", lowSeen, 0);
  endtask

  // Overlap shorter than the qualifying width must not start (R2).
  task automatic shortOverlap(input int n);
    int seen = 0;
    csN = 1'b0; ceN = 1'b0; rwN = 1'b0;
    repeat (n) tick();
    case ($urandom % 3)
      0: csN = 1'b1;
      1: ceN = 1'b1;
      default: rwN = 1'b1;
    endcase
    repeat (START_MIN + 3) begin
      tick();
      if (status) seen++;
    end
    chk(seen == 0, "R2 short overlap ignored", seen, 0);
    csN = 1'b1; ceN = 1'b1; rwN = 1'b1;
    tick();
  endtask

  // Repeating conversions, then final one after rwN rises (R8, R9).
  task automatic continuousRun(input logic [DATA_W-1:0] v0, input logic [DATA_W-1:0] v1,
                               input logic [DATA_W-1:0] v2);
    logic [DATA_W-1:0] vals [3];
    int highs, lows, seen;
    vals[0] = v0; vals[1] = v1; vals[2] = v2;
    vin = v0;
    csN = 1'b0; ceN = 1'b0; rwN = 1'b0;
    repeat (START_MIN) tick();
    chk(status == 1'b1, "R2 simultaneous fall", status, 1);
    for (int c = 0; c < 3; c++) begin
      highs = 1;
      forever begin
        tick();
        if (!status || highs > 40) break;
        highs++;
      end
      chk(highs == DATA_W, "R8 search length", highs, DATA_W);
      if (c < 2) begin
        vin = vals[c + 1];
        lows = 1;
        forever begin
          tick();
          if (status || lows > 40) break;
          chk(dataOe == 1'b0, "R5 bus in gap", dataOe, 0);
          lows++;
        end
        chk(lows == RESET_GAP, "R8 gap length", lows, RESET_GAP);
        if (c == 1) rwN = 1'b1;
      end
    end
    seen = 0;
    for (int i = 1; i < ACCESS_CYC; i++) begin
      tick();
      if (status) seen++;
    end
    tick();
    if (status) seen++;
    chk(seen == 0, "R9 no conversion after rise", seen, 0);
    chk(dataOe == 1'b1 && busData == sarModel(v2), "R9 final result kept", busData, sarModel(v2));
    ceN = 1'b1;
    repeat (HOLD_CYC + 1) tick();
    chk(dataOe == 1'b0, "R7 float after ceN", dataOe, 0);
    csN = 1'b1; rwN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) tick();
    chk(status == 1'b0 && dataOe == 1'b0, "R1 in reset", {status, dataOe}, 0);
    rstN = 1'b1;
    tick();
    chk(status == 1'b0 && dataOe == 1'b0, "R1 after reset", {status, dataOe}, 0);
    // Directed code corners (offset binary ends and midscale).
    convertAndRead(8'h00, 1'b0, 0);
    convertAndRead(8'hFF, 1'b0, 1);
    convertAndRead(8'h80, 1'b0, 2);
    convertAndRead(8'h7F, 1'b1, 0);
    for (int n = 1; n < START_MIN; n++) shortOverlap(n);
    continuousRun(8'h11, 8'hC4, 8'h5A);
    for (int i = 0; i < 30; i++) begin
      convertAndRead(DATA_W'($urandom), ($urandom % 4) == 0, int'($urandom % 3));
      if ((i % 5) == 0) shortOverlap(int'($urandom % (START_MIN - 1)) + 1);
    end
    continuousRun(DATA_W'($urandom), DATA_W'($urandom), DATA_W'($urandom));
    summary();
  end

endmodule